// File: doc/BRIEF.md
# Clock-Crossing AHB Slave Front End

This block is the bus-facing part of an AHB slave whose function logic runs on a second clock. That clock is slower than the bus clock or unrelated to it. A transfer is accepted in the bus clock and its word address and direction are frozen in registers. Write data is captured on the first data-phase cycle. A chip-select pulse then crosses into the function clock through a three-stage synchronizer.

No acknowledge comes back across the boundary. The slave holds HREADY low for a fixed, build-time number of bus cycles: one count for writes and another for reads. The read result is sampled back into the bus domain on the last of those wait cycles. The wait counts must be chosen long enough to cover the synchronizer latency and the function-side access.

The slave's word window is divided into up to four equal sub-slaves. The two most significant word-address bits pick one of them. In this project each sub-slave is a small bank of 32-bit registers in the function clock domain. One function-clock strobe per sub-slave is brought out so that the decode can be observed. A constant slave identifier is also driven on an output.

Top module: `xahb_xdom_slave`

## Requirements
- R1: While reset is asserted and right after it is released, hready_o is 1, hrdata_o is 0 and sub_cs_o is all zero.
- R2: A write transfer (htrans_i NONSEQ 2'b10 or SEQ 2'b11 with hsel_i and hready_i high) holds hready_o low for exactly WR_WAIT data-phase cycles. hready_o goes high in the next cycle.
- R3: A read transfer holds hready_o low for exactly RD_WAIT data-phase cycles. hrdata_o is valid in the cycle in which hready_o returns high.
- R4: The word address is haddr_i[WORD_AW+1:2], with WORD_AW = clog2(WORDS_TOTAL). Its top two bits select the sub-slave. An in-range transfer gives exactly one pulse, one function-clock cycle wide, on sub_cs_o[sub-slave index] and no pulse on any other bit.
- R5: Each sub-slave holds 2^(WORD_AW-2) words, indexed by the low word-address bits. A written word reads back unchanged, and writes to one word leave every other word unchanged.
- R6: A word address is out of range if it is WORDS_TOTAL or above, or if its sub-slave index is NUM_SUB or above. Such a transfer reads back 0, changes no stored word and pulses no sub_cs_o bit, but it still takes its full wait count.
- R7: IDLE (2'b00) and BUSY (2'b01) transfers complete with zero wait states, pulse no sub_cs_o bit and change no stored word.
- R8: hresp_o is always OKAY (2'b00).
- R9: The captured address and write data stay frozen for the whole transfer. Changes on haddr_i or hwdata_i after the first data-phase cycle have no effect on the stored word.
- R10: hrdata_o keeps the last read result through later write, IDLE and idle cycles until the next read completes.
- R11: slave_id_o always equals the SLAVE_ID parameter.
- R12: A new transfer may be presented in the cycle in which the previous transfer completes. It is accepted there, with no gap.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| hclk_i | input | 1 | Bus clock |
| fclk_i | input | 1 | Function clock |
| rst_ni | input | 1 | Active-low asynchronous reset, both domains |
| hsel_i | input | 1 | Slave select |
| haddr_i | input | 32 | Byte address |
| htrans_i | input | 2 | Transfer type |
| hwrite_i | input | 1 | 1 = write |
| hready_i | input | 1 | Bus ready into the slave |
| hwdata_i | input | 32 | Write data |
| hready_o | output | 1 | Transfer done |
| hresp_o | output | 2 | Response, always OKAY |
| hrdata_o | output | 32 | Read data |
| slave_id_o | output | 8 | Constant slave identifier |
| sub_cs_o | output | NUM_SUB | Function-clock chip-select strobe per sub-slave |

## Verification
After the address phase, the first data-phase cycle shows hready_o low. It stays low for exactly WR_WAIT or RD_WAIT bus cycles, and read data is due in the first cycle in which hready_o is high again. The bench drives inputs on falling bus-clock edges and counts low cycles one falling edge at a time, so each wait count is measured directly. It samples hrdata_o on the same falling edge on which hready_o is first seen high. Sub-slave strobes land a few function-clock cycles after the first data-phase cycle. They are counted on falling function-clock edges and compared only after the transfer completes, when the strobe is already past with margin.

// File: rtl/xahb_pkg.sv
package xahb_pkg;
  typedef enum logic [1:0] {
    TR_IDLE   = 2'b00,
    TR_BUSY   = 2'b01,
    TR_NONSEQ = 2'b10,
    TR_SEQ    = 2'b11
  } htrans_e;

  localparam logic [1:0] RESP_OKAY = 2'b00;
endpackage

// File: rtl/xahb_sync3.sv
module xahb_sync3 #(
  parameter int STAGES = 3
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic d_i,
  output logic q_o
);
  logic [STAGES-1:0] ff_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) ff_q <= '0;
    else         ff_q <= {ff_q[STAGES-2:0], d_i};
  end

  assign q_o = ff_q[STAGES-1];
endmodule

// File: rtl/xahb_sub_bank.sv
module xahb_sub_bank #(
  parameter int DW    = 32,
  parameter int IDX_W = 2
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             we_i,
  input  logic [IDX_W-1:0] idx_i,
  input  logic [DW-1:0]    wdata_i,
  output logic [DW-1:0]    rdata_o
);
  localparam int DEPTH = 2 ** IDX_W;

  logic [DW-1:0] mem_q [DEPTH];

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      for (int i = 0; i < DEPTH; i++) mem_q[i] <= '0;
    end else if (we_i) begin
      mem_q[idx_i] <= wdata_i;
    end
  end

  assign rdata_o = mem_q[idx_i];
endmodule

// File: rtl/xahb_bus_ctrl.sv
module xahb_bus_ctrl #(
  parameter int WORDS_TOTAL = 12,
  parameter int NUM_SUB     = 3,
  parameter int WR_WAIT     = 16,
  parameter int RD_WAIT     = 20,
  parameter int CS_WIDTH    = 4,
  parameter int WORD_AW     = 4
) (
  input  logic               hclk_i,
  input  logic               rst_ni,
  input  logic               hsel_i,
  input  logic [31:0]        haddr_i,
  input  logic [1:0]         htrans_i,
  input  logic               hwrite_i,
  input  logic               hready_i,
  input  logic [31:0]        hwdata_i,
  input  logic [31:0]        rdata_f_i,
  output logic               hready_o,
  output logic [31:0]        hrdata_o,
  output logic [WORD_AW-1:0] word_o,
  output logic [1:0]         sel_o,
  output logic               wr_o,
  output logic               in_range_o,
  output logic [31:0]        wdata_o,
  output logic               cs_o
);
  localparam int MAXW  = (WR_WAIT > RD_WAIT) ? WR_WAIT : RD_WAIT;
  localparam int CNT_W = $clog2(MAXW + 1);
  localparam int CS_CW = $clog2(CS_WIDTH + 1);

  logic               busy_q, first_q, wr_q, in_range_q, cs_q;
  logic [CNT_W-1:0]   cnt_q;
  logic [CS_CW-1:0]   cs_cnt_q;
  logic [WORD_AW-1:0] word_q;
  logic [1:0]         sel_q;
  logic [31:0]        wdata_q, hrdata_q;

  logic               accept, idle_slot, in_range_d;
  logic [WORD_AW-1:0] word_d;
  logic [1:0]         sel_d;
  logic               unused_bits;

  assign accept     = hsel_i && htrans_i[1] && hready_i;
  assign word_d     = haddr_i[WORD_AW+1:2];
  assign sel_d      = word_d[WORD_AW-1 -: 2];
  assign in_range_d = (int'(word_d) < WORDS_TOTAL) && (int'(sel_d) < NUM_SUB);
  assign idle_slot  = !busy_q || (cnt_q == '0);
  assign unused_bits = ^{haddr_i[31:WORD_AW+2], haddr_i[1:0], htrans_i[0]};

  always_ff @(posedge hclk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      busy_q     <= 1'b0;
      first_q    <= 1'b0;
      wr_q       <= 1'b0;
      in_range_q <= 1'b0;
      cnt_q      <= '0;
      word_q     <= '0;
      sel_q      <= '0;
      wdata_q    <= '0;
      hrdata_q   <= '0;
      cs_q       <= 1'b0;
      cs_cnt_q   <= '0;
    end else begin
      first_q <= 1'b0;
      if (idle_slot) begin
        busy_q <= accept;
        if (accept) begin
          word_q     <= word_d;
          sel_q      <= sel_d;
          wr_q       <= hwrite_i;
          in_range_q <= in_range_d;
          cnt_q      <= hwrite_i ? CNT_W'(WR_WAIT) : CNT_W'(RD_WAIT);
          first_q    <= 1'b1;
        end
      end else begin
        cnt_q <= cnt_q - 1'b1;
        // last wait cycle: function-side result has settled
        if (cnt_q == CNT_W'(1) && !wr_q) hrdata_q <= rdata_f_i;
      end

      if (first_q && wr_q) wdata_q <= hwdata_i;

      if (first_q) begin
        cs_q     <= 1'b1;
        cs_cnt_q <= CS_CW'(CS_WIDTH - 1);
      end else if (cs_q) begin
        if (cs_cnt_q == '0) cs_q <= 1'b0;
        else                cs_cnt_q <= cs_cnt_q - 1'b1;
      end
    end
  end

  assign hready_o   = idle_slot;
  assign hrdata_o   = hrdata_q;
  assign word_o     = word_q;
  assign sel_o      = sel_q;
  assign wr_o       = wr_q;
  assign in_range_o = in_range_q;
  assign wdata_o    = wdata_q;
  assign cs_o       = cs_q;
endmodule

// File: rtl/xahb_xdom_slave.sv
module xahb_xdom_slave
  import xahb_pkg::*;
#(
  parameter int         NUM_SUB     = 3,
  parameter int         WORDS_TOTAL = 12,
  parameter int         WR_WAIT     = 16,
  parameter int         RD_WAIT     = 20,
  parameter int         CS_WIDTH    = 4,
  parameter int         SYNC_STAGES = 3,
  parameter logic [7:0] SLAVE_ID    = 8'h5C
) (
  input  logic               hclk_i,
  input  logic               fclk_i,
  input  logic               rst_ni,
  input  logic               hsel_i,
  input  logic [31:0]        haddr_i,
  input  logic [1:0]         htrans_i,
  input  logic               hwrite_i,
  input  logic               hready_i,
  input  logic [31:0]        hwdata_i,
  output logic               hready_o,
  output logic [1:0]         hresp_o,
  output logic [31:0]        hrdata_o,
  output logic [7:0]         slave_id_o,
  output logic [NUM_SUB-1:0] sub_cs_o
);
  localparam int WORD_AW = $clog2(WORDS_TOTAL);
  localparam int IDX_W   = WORD_AW - 2;

  logic [WORD_AW-1:0] bus_word;
  logic [1:0]         bus_sel;
  logic               bus_wr, bus_in_range, bus_cs;
  logic [31:0]        bus_wdata, rdata_f_q, rd_pick;
  logic               cs_sync, cs_d_q, strobe;
  logic [31:0]        bank_rd [NUM_SUB];

  xahb_bus_ctrl #(
    .WORDS_TOTAL(WORDS_TOTAL), .NUM_SUB(NUM_SUB), .WR_WAIT(WR_WAIT),
    .RD_WAIT(RD_WAIT), .CS_WIDTH(CS_WIDTH), .WORD_AW(WORD_AW)
  ) u_bus (
    .hclk_i, .rst_ni, .hsel_i, .haddr_i, .htrans_i, .hwrite_i, .hready_i, .hwdata_i,
    .rdata_f_i (rdata_f_q),
    .hready_o, .hrdata_o,
    .word_o    (bus_word),
    .sel_o     (bus_sel),
    .wr_o      (bus_wr),
    .in_range_o(bus_in_range),
    .wdata_o   (bus_wdata),
    .cs_o      (bus_cs)
  );

  xahb_sync3 #(.STAGES(SYNC_STAGES)) u_cs_sync (
    .clk_i(fclk_i), .rst_ni, .d_i(bus_cs), .q_o(cs_sync)
  );

  always_ff @(posedge fclk_i or negedge rst_ni) begin
    if (!rst_ni) cs_d_q <= 1'b0;
    else         cs_d_q <= cs_sync;
  end

  assign strobe = cs_sync && !cs_d_q;

  // address, direction and data are frozen bus-side regs: multicycle into fclk
  for (genvar k = 0; k < NUM_SUB; k++) begin : g_sub
    assign sub_cs_o[k] = strobe && bus_in_range && (bus_sel == 2'(k));

    xahb_sub_bank #(.DW(32), .IDX_W(IDX_W)) u_bank (
      .clk_i  (fclk_i),
      .rst_ni,
      .we_i   (sub_cs_o[k] && bus_wr),
      .idx_i  (bus_word[IDX_W-1:0]),
      .wdata_i(bus_wdata),
      .rdata_o(bank_rd[k])
    );
  end

  always_comb begin
    rd_pick = '0;
    for (int k = 0; k < NUM_SUB; k++)
      if (bus_sel == 2'(k)) rd_pick = bank_rd[k];
  end

  always_ff @(posedge fclk_i or negedge rst_ni) begin
    if (!rst_ni)                 rdata_f_q <= '0;
    else if (strobe && !bus_wr)  rdata_f_q <= bus_in_range ? rd_pick : '0;
  end

  assign hresp_o    = RESP_OKAY;
  assign slave_id_o = SLAVE_ID;
endmodule

// File: rtl/xahb_xdom_slave_chk.sv
module xahb_xdom_slave_chk #(
  parameter int NUM_SUB  = 3,
  parameter int WR_WAIT  = 16,
  parameter int RD_WAIT  = 20,
  parameter int CS_WIDTH = 4,
  parameter int WORD_AW  = 4
) (
  input logic               hclk_i,
  input logic               fclk_i,
  input logic               rst_ni,
  input logic               hsel_i,
  input logic [1:0]         htrans_i,
  input logic               hwrite_i,
  input logic               hready_i,
  input logic               hready_o,
  input logic [NUM_SUB-1:0] sub_cs_o,
  input logic [WORD_AW-1:0] bus_word,
  input logic               bus_cs
);
  logic [15:0] low_cnt, cs_w;
  logic        exp_wr;

  always_ff @(posedge hclk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      low_cnt <= '0;
      cs_w    <= '0;
      exp_wr  <= 1'b0;
    end else begin
      low_cnt <= hready_o ? 16'd0 : low_cnt + 16'd1;
      cs_w    <= bus_cs ? cs_w + 16'd1 : 16'd0;
      if (hready_o && hsel_i && htrans_i[1] && hready_i) exp_wr <= hwrite_i;
    end
  end

  p_wr_wait_r2: assert property (@(posedge hclk_i) disable iff (!rst_ni)
    (hready_o && low_cnt != 0 && exp_wr) |-> low_cnt == 16'(WR_WAIT));

  p_rd_wait_r3: assert property (@(posedge hclk_i) disable iff (!rst_ni)
    (hready_o && low_cnt != 0 && !exp_wr) |-> low_cnt == 16'(RD_WAIT));

  p_cs_width_r4: assert property (@(posedge hclk_i) disable iff (!rst_ni)
    $fell(bus_cs) |-> cs_w == 16'(CS_WIDTH));

  p_sub_onehot_r4: assert property (@(posedge fclk_i) disable iff (!rst_ni)
    $onehot0(sub_cs_o));

  p_sub_single_r4: assert property (@(posedge fclk_i) disable iff (!rst_ni)
    (|sub_cs_o) |=> (sub_cs_o == '0));

  p_idle_no_wait_r7: assert property (@(posedge hclk_i) disable iff (!rst_ni)
    (hready_o && hready_i && hsel_i && !htrans_i[1]) |=> hready_o);

  p_addr_frozen_r9: assert property (@(posedge hclk_i) disable iff (!rst_ni)
    !hready_o |=> $stable(bus_word));
endmodule

bind xahb_xdom_slave xahb_xdom_slave_chk #(
  .NUM_SUB(NUM_SUB), .WR_WAIT(WR_WAIT), .RD_WAIT(RD_WAIT),
  .CS_WIDTH(CS_WIDTH), .WORD_AW(WORD_AW)
) u_chk (
  .hclk_i  (hclk_i),
  .fclk_i  (fclk_i),
  .rst_ni  (rst_ni),
  .hsel_i  (hsel_i),
  .htrans_i(htrans_i),
  .hwrite_i(hwrite_i),
  .hready_i(hready_i),
  .hready_o(hready_o),
  .sub_cs_o(sub_cs_o),
  .bus_word(bus_word),
  .bus_cs  (bus_cs)
);

// File: tb/xahb_xdom_slave_test.sv
module xahb_xdom_slave_test;
  localparam int         NSUB  = 3;
  localparam int         WORDS = 12;
  localparam int         WRW   = 16;
  localparam int         RDW   = 20;
  localparam logic [7:0] ID    = 8'h5C;
  localparam int         SPAN  = 16;  // 2^clog2(WORDS)
  localparam int         PER   = 4;   // words per sub-slave

  logic hclk_i = 1'b0, fclk_i = 1'b0, rst_ni = 1'b0;
  logic hsel_i = 1'b0, hwrite_i = 1'b0;
  logic [31:0] haddr_i = '0, hwdata_i = '0;
  logic [1:0]  htrans_i = 2'b00;
  logic        hready_i, hready_o;
  logic [1:0]  hresp_o;
  logic [31:0] hrdata_o;
  logic [7:0]  slave_id_o;
  logic [NSUB-1:0] sub_cs_o;

  assign hready_i = hready_o;

  always #2 hclk_i = ~hclk_i;
  always #5 fclk_i = ~fclk_i;

  xahb_xdom_slave #(
    .NUM_SUB(NSUB), .WORDS_TOTAL(WORDS), .WR_WAIT(WRW), .RD_WAIT(RDW),
    .CS_WIDTH(4), .SYNC_STAGES(3), .SLAVE_ID(ID)
  ) uut (.*);

  int checks = 0, fails = 0;
  int cs_seen [NSUB];
  logic [31:0] model [SPAN];
  logic [31:0] last_rd = '0;

  initial for (int k = 0; k < NSUB; k++) cs_seen[k] = 0;

  always @(negedge fclk_i)
    for (int k = 0; k < NSUB; k++) if (sub_cs_o[k]) cs_seen[k]++;

  task automatic check(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  function automatic bit in_rng(input int w);
    return (w < WORDS) && ((w / PER) < NSUB);
  endfunction

  // caller is at a falling edge; returns at the falling edge where hready_o is high
  task automatic xfer(input int w, input bit wr, input logic [31:0] wd, input bit perturb,
                      output logic [31:0] rd, output int waits);
    hsel_i = 1'b1; haddr_i = 32'(w) << 2; htrans_i = 2'b10; hwrite_i = wr;
    @(posedge hclk_i); @(negedge hclk_i);
    hsel_i = 1'b0; htrans_i = 2'b00; hwdata_i = wd;
    waits = 0;
    while (!hready_o && waits < 1000) begin
      waits++;
      if (perturb && waits == 2) begin haddr_i = 32'hFFFF_FFFC; hwdata_i = ~wd; end
      @(negedge hclk_i);
    end
    rd = hrdata_o;
  endtask

  task automatic cs_check(input int w, input int snap [NSUB], input string req);
    for (int k = 0; k < NSUB; k++) begin
      int exp = (in_rng(w) && (w / PER) == k) ? 1 : 0;
      check(cs_seen[k] - snap[k] == exp, req, 32'(cs_seen[k] - snap[k]), 32'(exp));
    end
  endtask

  task automatic do_write(input int w, input logic [31:0] d, input bit perturb);
    int snap [NSUB]; logic [31:0] rd; int waits;
    for (int k = 0; k < NSUB; k++) snap[k] = cs_seen[k];
    xfer(w, 1'b1, d, perturb, rd, waits);
    check(waits == WRW, "R2 write waits", 32'(waits), 32'(WRW));
    check(rd == last_rd, "R10 hrdata held over write", rd, last_rd);
    check(hresp_o == 2'b00, "R8 hresp", 32'(hresp_o), 32'h0);
    if (in_rng(w)) model[w] = d;
    cs_check(w, snap, in_rng(w) ? "R4 write sub_cs" : "R6 write out-of-range sub_cs");
  endtask

  task automatic do_read(input int w, input string req);
    int snap [NSUB]; logic [31:0] rd, exp; int waits;
    for (int k = 0; k < NSUB; k++) snap[k] = cs_seen[k];
    xfer(w, 1'b0, 32'h0, 1'b0, rd, waits);
    exp = in_rng(w) ? model[w] : 32'h0;
    check(waits == RDW, "R3 read waits", 32'(waits), 32'(RDW));
    check(rd == exp, req, rd, exp);
    last_rd = rd;
    cs_check(w, snap, in_rng(w) ? "R4 read sub_cs" : "R6 read out-of-range sub_cs");
  endtask

  task automatic no_wait_slot(input logic [1:0] tr, input int w);
    int snap [NSUB];
    for (int k = 0; k < NSUB; k++) snap[k] = cs_seen[k];
    hsel_i = 1'b1; haddr_i = 32'(w) << 2; htrans_i = tr; hwrite_i = 1'b1;
    @(posedge hclk_i); @(negedge hclk_i);
    hsel_i = 1'b0; htrans_i = 2'b00; hwdata_i = 32'hDEAD_BEEF;
    check(hready_o == 1'b1, "R7 no wait on idle/busy", 32'(hready_o), 32'h1);
    repeat (30) @(negedge hclk_i);
    for (int k = 0; k < NSUB; k++)
      check(cs_seen[k] == snap[k], "R7 no sub_cs on idle/busy", 32'(cs_seen[k] - snap[k]), 32'h0);
    check(hrdata_o == last_rd, "R10 hrdata held over idle", hrdata_o, last_rd);
  endtask

  initial begin
    for (int w = 0; w < SPAN; w++) model[w] = '0;
    repeat (5) @(negedge hclk_i);
    check(hready_o == 1'b1, "R1 reset hready", 32'(hready_o), 32'h1);
    check(hrdata_o == 32'h0, "R1 reset hrdata", hrdata_o, 32'h0);
    check(sub_cs_o == '0, "R1 reset sub_cs", 32'(sub_cs_o), 32'h0);
    rst_ni = 1'b1;
    repeat (3) @(negedge hclk_i);
    check(hready_o == 1'b1 && hrdata_o == 32'h0, "R1 after reset", hrdata_o, 32'h0);
    check(slave_id_o == ID, "R11 slave id", 32'(slave_id_o), 32'(ID));
    check(hresp_o == 2'b00, "R8 hresp idle", 32'(hresp_o), 32'h0);

    for (int w = 0; w < SPAN; w++)
      do_write(w, (32'h0101_0101 * 32'(w + 1)) ^ 32'hA5A5_0000, 1'b0);
    for (int w = 0; w < SPAN; w++)
      do_read(w, in_rng(w) ? "R5 readback" : "R6 out-of-range reads zero");

    do_write(5, 32'h1234_5678, 1'b1);
    do_read(5, "R9 frozen address and data");
    do_read(4, "R5 neighbour untouched");
    do_read(6, "R5 neighbour untouched");

    no_wait_slot(2'b00, 2);
    no_wait_slot(2'b01, 2);
    do_read(2, "R7 idle/busy left word unchanged");

    // back-to-back: each call presents its address in the previous completion cycle
    do_write(7, 32'hCAFE_F00D, 1'b0);
    do_read(7, "R12 pipelined read after write");
    do_write(13, 32'h7777_7777, 1'b0);
    do_read(13, "R6 out-of-range pipelined");
    do_write(9, 32'h0BAD_CAFE, 1'b0);
    do_read(9, "R12 pipelined sub-slave 2");

    repeat (8) @(negedge hclk_i);
    check(hrdata_o == last_rd, "R10 hrdata held while idle", hrdata_o, last_rd);

    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge hclk_i);
    checks++; fails++;
    $display("FAIL watchdog actual=%h expected=%h", 32'h1, 32'h0);
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end
endmodule